// File: doc/BRIEF.md
# Reload Down-Counter Timer

This block is a programmable down-counting timer meant to sit behind a simple peripheral write port. Software loads a start value into a reload register. It then arms the timer through a control register. A start comes either from a self-clearing software trigger bit or from a chosen transition on an external input. A start copies the reload value into the counter. The counter then decrements once for every cycle in which the count-tick enable input is high. A prescaler outside the block generates that tick.

When the counter passes from zero to all ones, the block raises an underflow flag. It can also raise an interrupt. In single-run operation the counter stops at all ones and waits for the next start. In continuous operation it reloads on the same tick and keeps going. The timer output is high while a count is in progress. Gated modes let the external input enable or block each tick instead of starting the count.

Top module: `reload_timer16`

## Requirements
- R1: A start happens only when the enable bit (control bit 0) is 1 after the write in progress, and either a control write sets the trigger bit (bit 1) or the selected edge is detected. An edge that arrives while the enable bit is 0 does not start the counter and does not change `count_q`.
- R2: A start loads the reload register (written with `wr_addr`=1) into the counter. A single control write that sets the enable bit and the trigger bit together makes `count_q` show the reload value after that clock edge.
- R3: While running, the counter decrements by one on each clock edge where `cnt_tick` is 1. It holds its value when `cnt_tick` is 0.
- R4: With the reload-select bit (bit 2) at 0, a tick at count 0 sets the counter to 0xFFFF and stops counting. The counter then stays at 0xFFFF through further ticks.
- R5: With the reload-select bit at 1, a tick at count 0 loads the reload value and counting continues without a new trigger.
- R6: Every underflow sets the underflow flag (bit 3). A control write with bit 3 at 0 clears the flag. A control write with bit 3 at 1 leaves the flag unchanged.
- R7: `irq` is 1 exactly while the underflow flag and the interrupt enable bit (bit 4) are both 1.
- R8: The mode field (bits 7:5) selects the start edge: 000 means no edge, 001 rising, 010 falling, 011 both. The external input passes through two synchronizer flops. A transition driven before clock edge k causes a load at edge k+2.
- R9: In mode 1xx the external input acts as a gate. Ticks count only while the synchronized input equals mode bit 5. Edges never start the counter in this mode.
- R10: The trigger bit always reads back as 0 in `ctrl_q`.
- R11: A control write with bit 0 at 0 stops counting on that same edge. `tout` goes low and the count is held.
- R12: `tout` is 1 exactly while a count is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count-clock enable from the prescaler |
| ext_in | input | 1 | External trigger or gate input, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects reload |
| wr_data | input | W | Write data |
| ctrl_q | output | 8 | Control/status readback |
| count_q | output | W | Current counter value |
| irq | output | 1 | Underflow interrupt request |
| tout | output | 1 | High while counting |

## Verification
The case that is hardest to reach is an external edge arriving when it has to be judged against a mode that was set up beforehand. The input must first settle at its starting level under a mode that ignores it. Only then is the edge mode armed and the input toggled. The bench does this for every edge mode and both directions, and for the disabled case. Each run uses a fresh reload value, so a load can be told apart from a held count. The gate modes are reached with a software start while the gate is closed, and then the gate is opened for a counted window.

// File: rtl/reload_timer16.sv
`timescale 1ns/1ps
module reload_timer16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_tick,
  input  logic         ext_in,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [7:0]   ctrl_q,
  output logic [W-1:0] count_q,
  output logic         irq,
  output logic         tout
);

  logic [W-1:0] reload_q, cnt_q;
  logic [2:0]   mode_q, sync_q;
  logic         en_q, rsel_q, uf_q, ie_q, run_q, edge_hit;

  wire ctrl_wr = wr_en & ~wr_addr;
  wire rld_wr  = wr_en & wr_addr;
  wire en_next = ctrl_wr ? wr_data[0] : en_q;
  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];

  always_comb begin
    case (mode_q)
      3'b001:  edge_hit = rise;
      3'b010:  edge_hit = fall;
      3'b011:  edge_hit = rise | fall;
      default: edge_hit = 1'b0;
    endcase
  end

  wire start   = en_next & ((ctrl_wr & wr_data[1]) | edge_hit);
  wire gate_ok = ~mode_q[2] | (sync_q[1] == mode_q[0]);
  wire step    = run_q & en_next & cnt_tick & gate_ok & ~start;
  wire under   = step & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      mode_q   <= '0;
      sync_q   <= '0;
      en_q     <= 1'b0;
      rsel_q   <= 1'b0;
      uf_q     <= 1'b0;
      ie_q     <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ext_in};
      if (rld_wr) reload_q <= wr_data;
      if (ctrl_wr) begin
        en_q   <= wr_data[0];
        rsel_q <= wr_data[2];
        ie_q   <= wr_data[4];
        mode_q <= wr_data[7:5];
        if (!wr_data[3]) uf_q <= 1'b0;
      end
      if (under) uf_q <= 1'b1;
      if (!en_next) begin
        run_q <= 1'b0;
      end else if (start) begin
        cnt_q <= reload_q;
        run_q <= 1'b1;
      end else if (step) begin
        if (cnt_q == '0) begin
          if (rsel_q) cnt_q <= reload_q;
          else begin
            cnt_q <= '1;
            run_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign ctrl_q  = {mode_q, ie_q, uf_q, rsel_q, 1'b0, en_q};
  assign count_q = cnt_q;
  assign irq     = uf_q & ie_q;
  assign tout    = run_q;

  a_r4_park: assert property (@(posedge clk) disable iff (!rst_n)
    (under && !rsel_q) |=> (cnt_q == '1 && !run_q));
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (under && rsel_q && en_next) |=> (run_q && cnt_q == $past(reload_q)));
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    under |=> uf_q);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!uf_q && !under) |=> !uf_q);
  a_r11_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_data[0]) |=> (!run_q && $stable(cnt_q)));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step) |=> $stable(cnt_q));
  a_r12_begin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(start));

endmodule

// File: tb/reload_timer16_tb.sv
`timescale 1ns/1ps
module reload_timer16_tb;
  logic        clk = 0, rst_n = 0, cnt_tick = 0, ext_in = 0;
  logic        wr_en = 0, wr_addr = 0;
  logic [15:0] wr_data = '0;
  logic [7:0]  ctrl_q;
  logic [15:0] count_q;
  logic        irq, tout;
  int checks = 0, errors = 0;

  reload_timer16 #(.W(16)) u_dut (.*);

  always #5 clk = ~clk;

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [15:0] cw(input logic en, trg, rs, uf, ie, input logic [2:0] m);
    return {8'h00, m, ie, uf, rs, trg, en};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] exp, prev;
    logic hit;
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R12 reset tout", tout, 0);
    chk("R4 reset count", count_q, 0);
    chk("R7 reset irq", irq, 0);
    chk("R6 reset ctrl", ctrl_q, 0);

    for (int n = 0; n < 6; n++) begin
      for (int dv = 1; dv <= 3; dv++) begin
        cnt_tick = 0;
        wr(1, 16'(n));
        wr(0, cw(1, 1, 0, 0, 0, 0));
        chk("R2 start loads reload", count_q, 16'(n));
        chk("R12 tout while counting", tout, 1);
        chk("R10 trigger reads 0", ctrl_q[1], 0);
        exp = 16'(n);
        for (int k = 0; k < 40; k++) begin
          cnt_tick = (k % dv) == 0;
          @(negedge clk);
          if (cnt_tick) exp = (exp == 0) ? 16'hFFFF : exp - 1;
          chk("R3 count step", count_q, exp);
          if (exp == 16'hFFFF) break;
        end
        chk("R4 stopped after underflow", tout, 0);
        chk("R6 flag set", ctrl_q[3], 1);
        cnt_tick = 1;
        cyc(3);
        chk("R4 parked at FFFF", count_q, 16'hFFFF);
        cnt_tick = 0;
      end
    end

    chk("R7 irq masked", irq, 0);
    wr(0, cw(1, 0, 0, 1, 1, 0));
    chk("R6 write 1 keeps flag", ctrl_q[3], 1);
    chk("R7 irq raised", irq, 1);
    wr(0, cw(1, 0, 0, 0, 1, 0));
    chk("R6 write 0 clears flag", ctrl_q[3], 0);
    chk("R7 irq dropped", irq, 0);
    wr(0, cw(1, 0, 0, 1, 1, 0));
    chk("R6 write 1 no set", ctrl_q[3], 0);
    chk("R7 irq stays low", irq, 0);

    wr(1, 16'd3);
    wr(0, cw(1, 1, 1, 0, 0, 0));
    exp = 3;
    cnt_tick = 1;
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      exp = (exp == 0) ? 16'd3 : exp - 1;
      chk("R5 reload sequence", count_q, exp);
      chk("R5 keeps running", tout, 1);
    end
    chk("R6 flag after reload underflow", ctrl_q[3], 1);

    prev = count_q;
    wr(0, cw(0, 0, 1, 0, 0, 0));
    chk("R11 held on disable", count_q, prev);
    chk("R11 tout low", tout, 0);
    cyc(3);
    chk("R11 stays held", count_q, prev);
    cnt_tick = 0;

    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        wr(0, cw(0, 0, 0, 0, 0, 0));
        ext_in = d[0] ? 1'b0 : 1'b1;
        cyc(4);
        wr(1, 16'h0100 + 16'(m * 2 + d));
        wr(0, cw(1, 0, 0, 0, 0, 3'(m)));
        prev = count_q;
        ext_in = ~ext_in;
        cyc(3);
        hit = (m == 3) || (m == 1 && d == 1) || (m == 2 && d == 0);
        chk("R8 edge mode start", count_q, hit ? 16'h0100 + 16'(m * 2 + d) : prev);
        chk("R1 tout after edge", tout, hit);
      end
    end

    wr(0, cw(0, 0, 0, 0, 0, 0));
    ext_in = 0;
    cyc(4);
    wr(1, 16'h0222);
    wr(0, cw(0, 0, 0, 0, 0, 3'b011));
    prev = count_q;
    ext_in = 1;
    cyc(4);
    chk("R1 edge ignored when disabled", count_q, prev);
    chk("R1 no run when disabled", tout, 0);

    wr(0, cw(0, 0, 0, 0, 0, 0));
    ext_in = 0;
    cyc(4);
    wr(1, 16'd20);
    wr(0, cw(1, 1, 0, 0, 0, 3'b101));
    chk("R9 gate start", count_q, 16'd20);
    cnt_tick = 1;
    cyc(4);
    chk("R9 gate closed holds", count_q, 16'd20);
    ext_in = 1;
    cyc(5);
    chk("R9 gate open counts", count_q, 16'd17);
    ext_in = 0;
    cyc(5);
    chk("R9 gate closes again", count_q, 16'd15);
    cnt_tick = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule